// File: doc/BRIEF.md
# GPIO Controller with Edge-Event Interrupts

This block is a 32-line general-purpose I/O controller on a simple word-wide register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to make each line an input or an output, to pick open-drain drive, to set the output value and to turn on each line's input buffer. Each line also gets edge-event capture. Every line's pin goes through a two-flop synchroniser. The synchronised value is then compared with its value one cycle earlier. An edge sets a sticky event flag, and software clears the flag by writing one to it. A per-line mask reduces the flags to one interrupt output.

Register bit ordering is reversed relative to line numbering. Line n lives in register bit 31-n. The pad-side vectors `pin_i`, `pin_o`, `pin_oe_o` and `pin_od_o` are indexed by line number.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0: all lines are inputs, push-pull, masked, both-edge, with input buffers off. `irq_o` is low and `pin_oe_o` is all zero.
- R2: Byte addresses 0x00 (direction), 0x04 (open-drain), 0x10 (mask), 0x14 (edge control) and 0x18 (input buffer enable) read back the last value written to them. Address 0x1C reads 0, and a write to it changes nothing.
- R3: Line n corresponds to register bit 31-n in every register. Pad vectors are indexed by line, so a direction value of 0x8000_0002 enables lines 0 and 30 (`pin_oe_o` = 0x4000_0001).
- R4: For line n, `pin_o[n]` is the output latch bit. `pin_od_o[n]` is the open-drain bit. `pin_oe_o[n]` is 1 only when the direction bit is 1 (output) and the line is not open-drain driving a 1.
- R5: A read of address 0x08 returns the output latch in bits whose direction is output. In the other bits it returns the synchronised pin value if that line's input buffer enable is 1, and 0 otherwise. A pin change shows up after the third rising clock edge.
- R6: An edge-control bit of 1 captures only falling edges on that line. A bit of 0 captures both edges. An event flag (address 0x0C) is set by the third rising clock edge after the pin change.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. With no write, a set flag stays set.
- R8: If a new edge and a clear of the same bit land in the same cycle, the flag stays set.
- R9: Events are captured whatever the mask. `irq_o` is high exactly when some bit of (event AND mask) is 1. A mask bit of 1 enables that line.
- R10: Edge capture works on every line, whatever its direction or input buffer enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | 32 | Pin levels, indexed by line |
| pin_o | output | 32 | Output value to pads, indexed by line |
| pin_oe_o | output | 32 | Output enable to pads, indexed by line |
| pin_od_o | output | 32 | Open-drain select to pads, indexed by line |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed sequences cover specific behaviours:
- An asymmetric direction value exposes any missing bit reversal.
- Rising and then falling pulses on one line separate falling-only capture from both-edge capture.
- A clear timed onto the cycle of a fresh edge shows whether the new event or the clear wins.
- Lines with the input buffer off or the direction set to output show that edge capture does not depend on those settings, while the data register does.

A long seeded random phase then toggles sparse pin bits and writes random data to random addresses, including the unused address. It compares every output each cycle against a requirement-level model, so cross-effects between registers and same-cycle write/edge collisions are caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 5'h00,
    A_OPEN = 5'h04,
    A_DATA = 5'h08,
    A_EVT  = 5'h0C,
    A_MASK = 5'h10,
    A_EDGE = 5'h14,
    A_IBUF = 5'h18
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_evt.sv
module gpio_irq_evt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] fall_only_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, hit;

  // rising edges are dropped on falling-only lines
  assign hit = (cur_i ^ prev_q) & ~(fall_only_i & cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_o  <= '0;
    end else begin
      prev_q <= cur_i;
      evt_o  <= (evt_o & ~clr_i) | hit;
    end
  end

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~hit) != '0) |=> ((evt_o & $past(clr_i & ~hit)) == '0));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_o & ~clr_i) & ~evt_o) == '0));

  assert_new_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((evt_o & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_pad.sv
module gpio_irq_pad #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] open_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] od_o
);
  for (genvar n = 0; n < W; n++) begin : g_line
    localparam int unsigned B = W - 1 - n;
    assign pin_o[n] = dat_i[B];
    assign od_o[n]  = open_i[B];
    // open-drain high releases the line
    assign oe_o[n]  = dir_i[B] & ~(open_i[B] & dat_i[B]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic [N_LINES-1:0] rd_data_o,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] pin_o,
  output logic [N_LINES-1:0] pin_oe_o,
  output logic [N_LINES-1:0] pin_od_o,
  output logic               irq_o
);
  localparam int unsigned W = N_LINES;

  logic [W-1:0] dir_q, open_q, dat_q, mask_q, edge_q, ibuf_q, in_q;
  logic [W-1:0] sync_line, sync_reg, dir_line, evt, clr;

  gpio_irq_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_line)
  );

  for (genvar n = 0; n < W; n++) begin : g_rev
    assign sync_reg[W-1-n] = sync_line[n];
    assign dir_line[n]     = dir_q[W-1-n];
  end

  assign clr = (wr_en_i && addr_i == A_EVT) ? wr_data_i : '0;

  gpio_irq_evt #(.W(W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (sync_reg),
    .fall_only_i(edge_q),
    .clr_i      (clr),
    .evt_o      (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      open_q <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      edge_q <= '0;
      ibuf_q <= '0;
      in_q   <= '0;
    end else begin
      in_q <= sync_reg & ibuf_q;
      if (wr_en_i) begin
        case (addr_i)
          A_DIR:   dir_q  <= wr_data_i;
          A_OPEN:  open_q <= wr_data_i;
          A_DATA:  dat_q  <= wr_data_i;
          A_MASK:  mask_q <= wr_data_i;
          A_EDGE:  edge_q <= wr_data_i;
          A_IBUF:  ibuf_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_DIR:   rd_data_o = dir_q;
      A_OPEN:  rd_data_o = open_q;
      A_DATA:  rd_data_o = (dat_q & dir_q) | (in_q & ~dir_q);
      A_EVT:   rd_data_o = evt;
      A_MASK:  rd_data_o = mask_q;
      A_EDGE:  rd_data_o = edge_q;
      A_IBUF:  rd_data_o = ibuf_q;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = |(evt & mask_q);

  gpio_irq_pad #(.W(W)) u_pad (
    .dir_i (dir_q),
    .open_i(open_q),
    .dat_i (dat_q),
    .pin_o (pin_o),
    .oe_o  (pin_oe_o),
    .od_o  (pin_od_o)
  );

  assert_oe_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~dir_line) == '0);

  assert_in_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((in_q & ~$past(ibuf_q)) == '0));

  assert_irq_needs_evt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt != '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_pin = '0;
  logic [31:0] rd, pin_o, pin_oe, pin_od;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .wr_en_i(b_we),
    .wr_data_i(b_wd), .rd_data_o(rd), .pin_i(b_pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .pin_od_o(pin_od), .irq_o(irq)
  );

  // model state, register order unless noted
  logic [31:0] m_dir = '0, m_od = '0, m_dat = '0, m_evt = '0, m_mask = '0;
  logic [31:0] m_ctl = '0, m_ibe = '0, m_in = '0, m_prev = '0;
  logic [31:0] m_s1 = '0, m_s2 = '0; // line order

  function automatic logic [31:0] rev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_dir;
      5'h04: return m_od;
      5'h08: return (m_dat & m_dir) | (m_in & ~m_dir);
      5'h0C: return m_evt;
      5'h10: return m_mask;
      5'h14: return m_ctl;
      5'h18: return m_ibe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h08: return "R5";
      5'h0C: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [31:0] cur, hit, clr;
    cur = rev(m_s2);
    hit = (cur ^ m_prev) & ~(m_ctl & cur);
    clr = (b_we && b_addr == 5'h0C) ? b_wd : 32'h0;
    m_evt  = (m_evt & ~clr) | hit;
    m_in   = cur & m_ibe;
    m_prev = cur;
    m_s2   = m_s1;
    m_s1   = b_pin;
    if (b_we) begin
      case (b_addr)
        5'h00: m_dir  = b_wd;
        5'h04: m_od   = b_wd;
        5'h08: m_dat  = b_wd;
        5'h10: m_mask = b_wd;
        5'h14: m_ctl  = b_wd;
        5'h18: m_ibe  = b_wd;
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    chk(tag_of(b_addr), rd, exp_rd(b_addr));
    chk("R9", {31'h0, irq}, {31'h0, |(m_evt & m_mask)});
    chk("R4", pin_o, rev(m_dat));
    chk("R4", pin_oe, rev(m_dir & ~(m_od & m_dat)));
    chk("R4", pin_od, rev(m_od));
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    b_addr = a; b_we = 1'b1; b_wd = d;
    tick();
    b_we = 1'b0;
  endtask

  task automatic rd_at(input logic [4:0] a);
    b_addr = a; b_we = 1'b0;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    // R1: reset state, read while reset held
    #5;
    for (int a = 0; a < 8; a++) begin
      b_addr = 5'(a * 4);
      #1;
      chk("R1", rd, 32'h0);
    end
    chk("R1", pin_oe, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: bit reversal
    wr(5'h00, 32'h8000_0002);
    chk("R3", pin_oe, 32'h4000_0001);

    // R4: open-drain high releases line 0
    wr(5'h04, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    chk("R4", pin_oe, 32'h4000_0000);
    chk("R4", pin_od, 32'h0000_0001);
    chk("R4", {31'h0, pin_o[0]}, 32'h1);

    // R2: unused address ignored
    wr(5'h1C, 32'hFFFF_FFFF);
    rd_at(5'h1C);
    chk("R2", rd, 32'h0);
    rd_at(5'h04);
    chk("R2", rd, 32'h8000_0000);

    // R6: falling-only on line 4 (bit 27)
    wr(5'h14, 32'h0800_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    b_pin[4] = 1'b1;
    for (int i = 0; i < 4; i++) rd_at(5'h0C);
    chk("R6", rd & 32'h0800_0000, 32'h0);
    b_pin[4] = 1'b0;
    for (int i = 0; i < 4; i++) rd_at(5'h0C);
    chk("R6", rd & 32'h0800_0000, 32'h0800_0000);

    // R8: clear lands on the cycle of a new edge
    wr(5'h14, 32'h0);
    b_pin[4] = 1'b1;
    rd_at(5'h0C);
    rd_at(5'h0C);
    wr(5'h0C, 32'h0800_0000);
    chk("R8", rd & 32'h0800_0000, 32'h0800_0000);

    // R7: write 0 keeps, write 1 clears
    wr(5'h0C, 32'h0);
    chk("R7", rd & 32'h0800_0000, 32'h0800_0000);
    wr(5'h0C, 32'h0800_0000);
    chk("R7", rd & 32'h0800_0000, 32'h0);

    // R9: mask gates only the interrupt
    b_pin[4] = 1'b0;
    for (int i = 0; i < 4; i++) rd_at(5'h0C);
    chk("R9", rd & 32'h0800_0000, 32'h0800_0000);
    chk("R9", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0800_0000);
    chk("R9", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'h0800_0000);
    chk("R9", {31'h0, irq}, 32'h0);

    // R5 / R10: buffer enable on line 7 only; line 8 still captures edges
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0100_0000);
    b_pin[7] = 1'b1;
    b_pin[8] = 1'b1;
    rd_at(5'h08);
    rd_at(5'h08);
    chk("R5", rd & 32'h0180_0000, 32'h0);
    rd_at(5'h08);
    chk("R5", rd, 32'h0100_0000);
    rd_at(5'h0C);
    chk("R10", rd & 32'h0180_0000, 32'h0180_0000);
    // output line reads latch, not pin
    wr(5'h08, 32'h0000_0000);
    wr(5'h00, 32'h0100_0000);
    rd_at(5'h08);
    chk("R5", rd & 32'h0100_0000, 32'h0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) b_pin = b_pin ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) b_pin = b_pin ^ $urandom;
      b_addr = 5'($urandom_range(0, 7) * 4);
      b_we   = ($urandom_range(0, 3) == 0);
      b_wd   = $urandom;
      if (b_addr == 5'h0C && $urandom_range(0, 1) == 0) b_wd = b_wd & $urandom;
      tick();
    end
    b_we = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule